// File: doc/BRIEF.md
# Two-Wire Programming Port Command Engine

This block is the target side of a two-wire serial programming port. A host drives a slow clock line and a bidirectional data line. Every transaction carries a 4-bit command followed by a 16-bit payload. Both lines are brought into the system clock domain through two-flop synchronizers. Input bits are taken on the falling edge of the port clock, and output bits are changed on its rising edge. Every field travels least significant bit first.

Command `0000` passes its payload to the core as an instruction word. Command `0010` turns the data line around and shifts a 16-bit word out. Every other code is consumed and discarded. After the command field and after the payload, the host must hold off for a programmed number of system clocks. Port clock edges inside these hold-offs are rejected and latch an error flag.

The core reports that it has executed a write-start instruction. The block then raises the nonvolatile write strobe on the fourth accepted falling edge that follows. When the core reports that programming is complete, the block opens a discharge window. Port clock activity inside that window is also rejected.

Top module: `pgm_port`

## Requirements
- R1: After reset, `pgd_oe`, `exec_valid`, `wr_start`, `disch_active` and `proto_err` are all 0.
- R2: Command code `0000` (first bit received is command bit 0) followed by a 16-bit payload gives one `exec_valid` pulse. On that pulse, `exec_instr` equals the payload, with the first payload bit received placed in bit 0.
- R3: Command code `0010` captures `rd_data` at the start of the payload. It drives `pgd_oe` high and presents bit k of the captured word on `pgd_out` after the (k+1)-th rising port clock edge of the payload. The data line is ignored while the word is shifted out.
- R4: `pgd_oe` falls within one system clock of the accepted falling edge that ends the 16th payload bit.
- R5: Any command code other than `0000` or `0010` gives no `exec_valid` pulse and leaves `pgd_oe` low.
- R6: During the P5_CYC hold-off after the command field, any port clock edge sets `proto_err` and is ignored, so that the next transaction decodes correctly.
- R7: During the P5A_CYC hold-off after the payload, any port clock edge sets `proto_err` and is ignored.
- R8: After a `wr_set` pulse, `wr_start` pulses exactly once. The pulse follows the 4th accepted falling port clock edge, and no earlier edge produces it.
- R9: A `prog_done` pulse makes `disch_active` high for exactly DISCH_CYC system clocks. Port clock edges inside that window set `proto_err` and are ignored.
- R10: `proto_err` stays at 1 once set, until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pgc_pin | input | 1 | Port clock from the host (asynchronous) |
| pgd_in | input | 1 | Data line as received from the pad |
| pgd_out | output | 1 | Data line value driven to the pad |
| pgd_oe | output | 1 | Pad output enable for the data line |
| exec_valid | output | 1 | One-cycle strobe: instruction word ready |
| exec_instr | output | 16 | Instruction word for the core |
| rd_data | input | 16 | Word to be shifted out by command 0010 |
| wr_set | input | 1 | Core has executed a write-start instruction |
| wr_start | output | 1 | One-cycle nonvolatile write start strobe |
| prog_done | input | 1 | Programming has ended; open the discharge window |
| disch_active | output | 1 | Discharge window open; port clock must stay low |
| proto_err | output | 1 | Sticky protocol-violation flag |

## Verification
The hardest situations to reach from the ports are port clock edges that fall inside a hold-off window. To produce them, the bench must place short clock pulses a few system clocks into the P5 and P5A counts and into the discharge window, and allow for the synchronizer latency. Once each such pulse has been injected, the bench lets the window expire. It then runs a normal transaction whose decoded instruction shows whether the stray edges were counted. The write strobe position is checked separately: the bench numbers every falling edge it drives and records that number when the strobe appears.

// File: rtl/pgm_port_pkg.sv
package pgm_port_pkg;
  localparam int CMD_W = 4;
  localparam int PAY_W = 16;
  localparam logic [CMD_W-1:0] CMD_CORE  = 4'b0000;
  localparam logic [CMD_W-1:0] CMD_SHOUT = 4'b0010;

  typedef enum logic [1:0] {ST_CMD, ST_GAP1, ST_PAY, ST_GAP2} pst_t;

  // LSB-first shift: new bit enters at the top, oldest ends at bit 0
  function automatic logic [CMD_W-1:0] cmd_shift(logic [CMD_W-1:0] sr, logic b);
    return {b, sr[CMD_W-1:1]};
  endfunction

  function automatic logic [PAY_W-1:0] pay_shift(logic [PAY_W-1:0] sr, logic b);
    return {b, sr[PAY_W-1:1]};
  endfunction
endpackage

// File: rtl/pgm_sync.sv
module pgm_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] chain [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= '0;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= '0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/pgm_fsm.sv
module pgm_fsm
  import pgm_port_pkg::*;
#(
  parameter int P5_CYC  = 12,
  parameter int P5A_CYC = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pgc_s,
  input  logic             pgd_s,
  input  logic             hold_ext,
  input  logic [PAY_W-1:0] rd_data,
  output logic             exec_valid,
  output logic [PAY_W-1:0] exec_instr,
  output logic             pgd_out,
  output logic             pgd_oe,
  output logic             fall_ok,
  output logic             proto_err
);
  localparam int GMAX = (P5_CYC > P5A_CYC) ? P5_CYC : P5A_CYC;
  localparam int GW   = $clog2(GMAX + 1);
  localparam int BW   = $clog2(PAY_W + 1);

  pst_t             st;
  logic             pgc_d;
  logic [GW-1:0]    gap_cnt;
  logic [BW-1:0]    bitcnt;
  logic [CMD_W-1:0] cmd_sr;
  logic [PAY_W-1:0] pay_sr, out_sr;

  // named events for assertions
  logic rise, fall, gap_busy, hold, rise_ok, last_fall;
  assign rise      = pgc_s & ~pgc_d;
  assign fall      = ~pgc_s & pgc_d;
  assign gap_busy  = (st == ST_GAP1) || (st == ST_GAP2);
  assign hold      = gap_busy || hold_ext;
  assign fall_ok   = fall && !hold;
  assign rise_ok   = rise && !hold;
  assign last_fall = fall_ok && (st == ST_PAY) && (bitcnt == BW'(PAY_W-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= ST_CMD; pgc_d <= 1'b0; gap_cnt <= '0; bitcnt <= '0;
      cmd_sr <= '0; pay_sr <= '0; out_sr <= '0;
      exec_valid <= 1'b0; exec_instr <= '0;
      pgd_out <= 1'b0; pgd_oe <= 1'b0; proto_err <= 1'b0;
    end else begin
      pgc_d      <= pgc_s;
      exec_valid <= 1'b0;
      if ((rise || fall) && hold) proto_err <= 1'b1;
      case (st)
        ST_CMD: if (fall_ok) begin
          cmd_sr <= cmd_shift(cmd_sr, pgd_s);
          if (bitcnt == BW'(CMD_W-1)) begin
            bitcnt <= '0; st <= ST_GAP1; gap_cnt <= GW'(P5_CYC);
          end else bitcnt <= bitcnt + 1'b1;
        end
        ST_GAP1: begin
          if (gap_cnt <= GW'(1)) begin
            st <= ST_PAY;
            if (cmd_sr == CMD_SHOUT) begin
              out_sr <= rd_data; pgd_oe <= 1'b1;
            end
          end else gap_cnt <= gap_cnt - 1'b1;
        end
        ST_PAY: begin
          if (rise_ok && cmd_sr == CMD_SHOUT) begin
            pgd_out <= out_sr[0];
            out_sr  <= out_sr >> 1;
          end
          if (fall_ok) begin
            pay_sr <= pay_shift(pay_sr, pgd_s);
            if (last_fall) begin
              bitcnt <= '0; st <= ST_GAP2; gap_cnt <= GW'(P5A_CYC);
              pgd_oe <= 1'b0;
              if (cmd_sr == CMD_CORE) begin
                exec_valid <= 1'b1;
                exec_instr <= pay_shift(pay_sr, pgd_s);
              end
            end else bitcnt <= bitcnt + 1'b1;
          end
        end
        default: begin
          if (gap_cnt <= GW'(1)) st <= ST_CMD;
          else gap_cnt <= gap_cnt - 1'b1;
        end
      endcase
    end
  end

  a_r4_oe_release: assert property (@(posedge clk) disable iff (!rst_n)
    last_fall |=> !pgd_oe);
  a_r3_oe_only_in_payload: assert property (@(posedge clk) disable iff (!rst_n)
    pgd_oe |-> (st == ST_PAY || st == ST_GAP2));
  a_r6_gap_edge_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (gap_busy && (rise || fall)) |=> proto_err);
  a_r10_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    proto_err |=> proto_err);
  a_r2_exec_after_payload: assert property (@(posedge clk) disable iff (!rst_n)
    exec_valid |-> (st == ST_GAP2 && $past(fall_ok)));
endmodule

// File: rtl/pgm_wrtimer.sv
module pgm_wrtimer #(
  parameter int DISCH_CYC = 30,
  parameter int EDGE_N    = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_set,
  input  logic fall_ok,
  input  logic prog_done,
  output logic wr_start,
  output logic disch_active
);
  localparam int EW = $clog2(EDGE_N + 1);
  localparam int DW = $clog2(DISCH_CYC + 1);

  logic          armed;
  logic [EW-1:0] ecnt;
  logic [DW-1:0] dcnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0; ecnt <= '0; wr_start <= 1'b0; dcnt <= '0;
    end else begin
      wr_start <= 1'b0;
      if (wr_set) begin
        armed <= 1'b1; ecnt <= '0;
      end else if (armed && fall_ok) begin
        if (ecnt == EW'(EDGE_N-1)) begin
          wr_start <= 1'b1; armed <= 1'b0;
        end else ecnt <= ecnt + 1'b1;
      end
      if (prog_done)        dcnt <= DW'(DISCH_CYC);
      else if (dcnt != '0)  dcnt <= dcnt - 1'b1;
    end
  end

  assign disch_active = (dcnt != '0);

  a_r8_start_on_edge: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |-> $past(fall_ok) && $past(armed));
  a_r8_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    wr_start |=> !wr_start);
  a_r9_window_opens: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(disch_active) |-> $past(prog_done));
endmodule

// File: rtl/pgm_port.sv
module pgm_port
  import pgm_port_pkg::*;
#(
  parameter int P5_CYC    = 12,
  parameter int P5A_CYC   = 12,
  parameter int DISCH_CYC = 30,
  parameter int SYNC_N    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pgc_pin,
  input  logic             pgd_in,
  output logic             pgd_out,
  output logic             pgd_oe,
  output logic             exec_valid,
  output logic [PAY_W-1:0] exec_instr,
  input  logic [PAY_W-1:0] rd_data,
  input  logic             wr_set,
  output logic             wr_start,
  input  logic             prog_done,
  output logic             disch_active,
  output logic             proto_err
);
  logic [1:0] pins_s;
  logic       fall_ok;

  pgm_sync #(.W(2), .STAGES(SYNC_N)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({pgc_pin, pgd_in}), .q(pins_s));

  pgm_fsm #(.P5_CYC(P5_CYC), .P5A_CYC(P5A_CYC)) u_fsm (
    .clk(clk), .rst_n(rst_n), .pgc_s(pins_s[1]), .pgd_s(pins_s[0]),
    .hold_ext(disch_active), .rd_data(rd_data),
    .exec_valid(exec_valid), .exec_instr(exec_instr),
    .pgd_out(pgd_out), .pgd_oe(pgd_oe), .fall_ok(fall_ok),
    .proto_err(proto_err));

  pgm_wrtimer #(.DISCH_CYC(DISCH_CYC), .EDGE_N(4)) u_wr (
    .clk(clk), .rst_n(rst_n), .wr_set(wr_set), .fall_ok(fall_ok),
    .prog_done(prog_done), .wr_start(wr_start),
    .disch_active(disch_active));
endmodule

// File: tb/tb_pgm_port.sv
module tb_pgm_port;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 6;
  localparam int P5 = 12, P5A = 12, DISCH = 30;

  logic clk = 0, rst_n = 0, pgc_pin = 0, pgd_in = 0, wr_set = 0, prog_done = 0;
  logic [15:0] rd_data = '0;
  logic pgd_out, pgd_oe, exec_valid, wr_start, disch_active, proto_err;
  logic [15:0] exec_instr;

  int checks = 0, errors = 0;
  int exec_cnt = 0, wr_cnt = 0, wr_idx = -1, fall_idx = 0, disch_len = 0;
  logic [15:0] last_instr = '0;
  logic [15:0] shout_word;
  logic oe_seen;
  bit done = 0;

  pgm_port #(.P5_CYC(P5), .P5A_CYC(P5A), .DISCH_CYC(DISCH)) dut (
    .clk(clk), .rst_n(rst_n), .pgc_pin(pgc_pin), .pgd_in(pgd_in),
    .pgd_out(pgd_out), .pgd_oe(pgd_oe), .exec_valid(exec_valid),
    .exec_instr(exec_instr), .rd_data(rd_data), .wr_set(wr_set),
    .wr_start(wr_start), .prog_done(prog_done),
    .disch_active(disch_active), .proto_err(proto_err));

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(negedge clk) begin
    if (exec_valid) begin exec_cnt++; last_instr = exec_instr; end
    if (wr_start) begin wr_cnt++; if (wr_idx < 0) wr_idx = fall_idx; end
    if (disch_active) disch_len++;
  end

  function automatic bit expect_exec(logic [3:0] code);
    return code == 4'b0000;
  endfunction

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wclk(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_in(logic b);
    pgd_in = b; pgc_pin = 1; wclk(HALF);
    pgc_pin = 0; fall_idx++; wclk(HALF);
  endtask

  task automatic do_reset();
    rst_n = 0; pgc_pin = 0; pgd_in = 0; wclk(3); rst_n = 1; wclk(3);
  endtask

  // glitch inside a hold-off window
  task automatic glitch();
    pgc_pin = 1; wclk(2); pgc_pin = 0; wclk(2);
  endtask

  task automatic xact(logic [3:0] code, logic [15:0] pay, bit g1, bit g2);
    for (int i = 0; i < 4; i++) bit_in(code[i]);
    if (g1) glitch();
    wclk(P5 + 2);
    oe_seen = 0; shout_word = '0;
    for (int i = 0; i < 16; i++) begin
      if (code == 4'b0010) begin
        pgd_in = $urandom; pgc_pin = 1; wclk(HALF);
        shout_word[i] = pgd_out; oe_seen |= pgd_oe;
        pgc_pin = 0; fall_idx++; wclk(HALF);
      end else bit_in(pay[i]);
      oe_seen |= pgd_oe;
    end
    if (g2) glitch();
    wclk(P5A + 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [3:0] code;
    logic [15:0] pay;
    int ec;
    void'($urandom(32'h5eed));
    do_reset();
    chk("R1 oe", pgd_oe, 0); chk("R1 exec", exec_valid, 0);
    chk("R1 wr", wr_start, 0); chk("R1 disch", disch_active, 0);
    chk("R1 err", proto_err, 0);

    // directed corners then random mix
    for (int t = 0; t < 24; t++) begin
      case (t)
        0: begin code = 4'b0000; pay = 16'h0001; end
        1: begin code = 4'b0000; pay = 16'h8000; end
        2: begin code = 4'b0010; pay = 16'h0; rd_data = 16'hA5C3; end
        3: begin code = 4'b0011; pay = 16'hFFFF; end
        default: begin
          case ($urandom % 3)
            0: code = 4'b0000;
            1: code = 4'b0010;
            default: code = 4'($urandom);
          endcase
          pay = 16'($urandom); rd_data = 16'($urandom);
        end
      endcase
      ec = exec_cnt;
      xact(code, pay, 0, 0);
      if (code == 4'b0000) begin
        chk("R2 exec count", exec_cnt - ec, 1);
        chk("R2 instr", last_instr, pay);
      end else if (code == 4'b0010) begin
        chk("R3 shout data", shout_word, rd_data);
        chk("R3 oe during payload", oe_seen, 1);
        chk("R4 oe released", pgd_oe, 0);
        chk("R3 no exec", exec_cnt - ec, 0);
      end else begin
        chk("R5 no exec", exec_cnt - ec, int'(expect_exec(code)));
        chk("R5 oe low", oe_seen, 0);
      end
    end
    chk("R10 no err in clean traffic", proto_err, 0);

    // R8 write strobe on 4th accepted fall
    wr_set = 1; wclk(1); wr_set = 0; fall_idx = 0; wr_cnt = 0; wr_idx = -1;
    xact(4'b0000, 16'h1234, 0, 0);
    chk("R8 strobe edge index", wr_idx, 4);
    chk("R8 single strobe", wr_cnt, 1);

    // R6 glitch in command hold-off
    do_reset();
    xact(4'b0000, 16'hBEEF, 1, 0);
    chk("R6 err set", proto_err, 1);
    chk("R6 payload intact", last_instr, 16'hBEEF);

    // R7 glitch in payload hold-off
    do_reset();
    xact(4'b0000, 16'h0F0F, 0, 1);
    chk("R7 err set", proto_err, 1);
    xact(4'b0000, 16'h7001, 0, 0);
    chk("R7 next xact aligned", last_instr, 16'h7001);
    chk("R10 err sticky", proto_err, 1);

    // R9 discharge window
    do_reset();
    disch_len = 0;
    prog_done = 1; wclk(1); prog_done = 0; wclk(1);
    chk("R9 window open", disch_active, 1);
    glitch();
    wclk(DISCH + 4);
    chk("R9 window length", disch_len, DISCH);
    chk("R9 err set", proto_err, 1);
    xact(4'b0000, 16'hC0DE, 0, 0);
    chk("R9 edges ignored", last_instr, 16'hC0DE);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule